// File: doc/BRIEF.md
# Dual Write-Combining Store Queue with Burst Drain

This block holds two small write-combining buffers of eight 32-bit words each, sixteen words in all. A processor fills the buffers with randomly addressed longword stores and can read any word back at any time. A flush command then drains one whole buffer to external memory as a single eight-beat burst. The burst is issued on a simple valid/ready master interface.

The flush request carries an address and a translation-mode flag. With translation off, the burst target is spliced from the middle bits of the request address and a three-bit high-address field. That field is held in one of two per-buffer control registers, and the control registers are loaded through their own write port. With translation on, the request address is already the physical target and is only aligned and masked.

While a buffer is draining, stores aimed at that buffer are stalled. Stores to the other buffer continue. A second flush cannot start until the running burst has finished.

Top module: `sq_burst_writer`

## Requirements
- R1: After reset no burst is active (`busy` and `bus_valid` low), every one of the 16 words reads as zero, and both high-address fields are zero.
- R2: A store or read selects its word with `cpu_addr[5:2]`. Bit 5 is the buffer number and bits 4:2 are the word within the buffer. All other address bits have no effect.
- R3: A flush drains the buffer named by `flush_addr[5]`. It sends 8 beats carrying words 0 through 7 of that buffer in ascending order, and `bus_last` is high only on the beat carrying word 7.
- R4: With `flush_xlat` low, `bus_addr` is 0 in bits 31:29, equals the selected buffer's high-address field in bits 28:26, equals `flush_addr[25:5]` in bits 25:5, and is 0 in bits 4:0.
- R5: A control write with `ctl_sel` = 0 or 1 loads buffer 0's or buffer 1's high-address field from `ctl_wdata[4:2]`. Every other bit of `ctl_wdata` is discarded.
- R6: With `flush_xlat` high, `bus_addr` equals `flush_addr[28:5]` in bits 28:5, with bits 31:29 and 4:0 zero. The high-address fields are not used.
- R7: A beat is accepted on a clock edge where `bus_valid` and `bus_ready` are both high. While `bus_ready` is low, `bus_addr`, `bus_data` and `bus_last` hold their values.
- R8: `busy` rises on the edge after a flush is accepted and falls on the edge that accepts the last beat. A flush request made while `busy` is high is dropped and does not start a later burst.
- R9: While a buffer is draining, `cpu_wr_ready` is low for stores to that buffer and the word does not change. Stores to the other buffer are accepted at once. The stalled store goes through after the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_valid | input | 1 | Longword store request |
| cpu_wr_ready | output | 1 | Store accepted this cycle |
| cpu_addr | input | 32 | Store/read address (bits 5:2 used) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Word selected by `cpu_addr`, combinational |
| ctl_wr_en | input | 1 | High-address control register write strobe |
| ctl_sel | input | 1 | Which buffer's control register is written |
| ctl_wdata | input | 32 | Control write data (bits 4:2 kept) |
| flush_req | input | 1 | Flush command |
| flush_addr | input | 32 | Flush address (bit 5 picks the buffer) |
| flush_xlat | input | 1 | 1: address is already translated |
| busy | output | 1 | Burst in progress |
| bus_valid | output | 1 | Burst beat valid |
| bus_ready | input | 1 | Burst beat accepted by memory |
| bus_addr | output | 32 | 32-byte aligned burst target |
| bus_data | output | 32 | Beat data |
| bus_last | output | 1 | Final beat of the burst |

## Verification
The embedded properties check the burst handshake on every cycle. A stalled beat keeps its address and beat number, an accepted beat advances by exactly one, the last accepted beat ends the burst, and an accepted flush starts at beat 0. They also check on every cycle that no store ever lands in the buffer being drained. Only the bench's scenarios can show that the right buffer's data arrives in word order, that the spliced and translated target addresses carry the expected bits, that control writes keep only their three field bits, and that a flush dropped during a busy burst never runs later.

// File: rtl/sqbw_pkg.sv
package sqbw_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 32;
    localparam int NUM_Q       = 2;
    localparam int WORDS_PER_Q = 8;
    localparam int WORD_BYTES  = DATA_W / 8;
    localparam int BYTE_OFF_W  = $clog2(WORD_BYTES);
    localparam int WIDX_W      = $clog2(WORDS_PER_Q);
    localparam int QSEL_W      = $clog2(NUM_Q);
    localparam int IDX_W       = QSEL_W + WIDX_W;
    localparam int TOTAL_WORDS = NUM_Q * WORDS_PER_Q;
    localparam int LINE_OFF_W  = BYTE_OFF_W + WIDX_W;
    localparam int QBIT        = LINE_OFF_W;
    localparam int PHYS_W      = 29;
    localparam int HI_W        = 3;
    localparam int HI_LSB      = PHYS_W - HI_W;
    localparam int CTL_LSB     = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } burst_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] target;
        logic [QSEL_W-1:0] qsel;
    } burst_cmd_t;

    function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
        return a[BYTE_OFF_W +: IDX_W];
    endfunction

    function automatic logic [ADDR_W-1:0] build_target(
        input logic [ADDR_W-1:0] fa,
        input logic [HI_W-1:0]   hi,
        input logic              xlat
    );
        logic [ADDR_W-1:0] t;
        t = '0;
        if (xlat) begin
            t[PHYS_W-1:LINE_OFF_W] = fa[PHYS_W-1:LINE_OFF_W];
        end else begin
            t[HI_LSB-1:LINE_OFF_W] = fa[HI_LSB-1:LINE_OFF_W];
            t[PHYS_W-1:HI_LSB]     = hi;
        end
        return t;
    endfunction

endpackage

// File: rtl/sqbw_storage.sv
module sqbw_storage
    import sqbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              burst_active,
    input  logic [IDX_W-1:0]  burst_idx,
    output logic [DATA_W-1:0] burst_data
);

    logic [DATA_W-1:0] words [TOTAL_WORDS];

    genvar gi;
    generate
        for (gi = 0; gi < TOTAL_WORDS; gi++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[gi] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                    words[gi] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data    = words[rd_idx];
    assign burst_data = words[burst_idx];

    // R9: the buffer being drained never receives a store
    p_no_store_into_drain_r9: assert property (@(posedge clk) disable iff (rst)
        burst_active |-> !(wr_en && (wr_idx[IDX_W-1 -: QSEL_W] == burst_idx[IDX_W-1 -: QSEL_W])));

endmodule

// File: rtl/sqbw_target.sv
module sqbw_target
    import sqbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_en,
    input  logic [QSEL_W-1:0] ctl_sel,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              flush_xlat,
    output burst_cmd_t        cmd
);

    logic [HI_W-1:0] hi_field [NUM_Q];

    genvar gq;
    generate
        for (gq = 0; gq < NUM_Q; gq++) begin : g_ctl
            always_ff @(posedge clk) begin
                if (rst) begin
                    hi_field[gq] <= '0;
                end else if (ctl_wr_en && (ctl_sel == QSEL_W'(gq))) begin
                    hi_field[gq] <= ctl_wdata[CTL_LSB +: HI_W];
                end
            end
        end
    endgenerate

    logic [QSEL_W-1:0] q;
    assign q          = flush_addr[QBIT +: QSEL_W];
    assign cmd.qsel   = q;
    assign cmd.target = build_target(flush_addr, hi_field[q], flush_xlat);

endmodule

// File: rtl/sqbw_burst_ctrl.sv
module sqbw_burst_ctrl
    import sqbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_req,
    input  burst_cmd_t        cmd,
    input  logic              bus_ready,
    output logic              bus_valid,
    output logic              bus_last,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [QSEL_W-1:0] cur_q,
    output logic [WIDX_W-1:0] beat
);

    localparam logic [WIDX_W-1:0] LAST_BEAT = WIDX_W'(WORDS_PER_Q - 1);

    burst_state_e      state;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            beat   <= '0;
            addr_q <= '0;
            cur_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (flush_req) begin
                        addr_q <= cmd.target;
                        cur_q  <= cmd.qsel;
                        beat   <= '0;
                        state  <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (bus_ready) begin
                        if (beat == LAST_BEAT) begin
                            beat  <= '0;
                            state <= ST_IDLE;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_valid = (state == ST_SEND);
    assign bus_last  = bus_valid && (beat == LAST_BEAT);
    assign bus_addr  = addr_q;

    // R1: reset leaves the burst engine idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !bus_valid);

    // R7: stalled beat holds its address and position
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(beat) && $stable(bus_addr) && $stable(cur_q)));

    // R3: accepted non-final beat advances by one
    p_beat_step_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && !bus_last) |=> (bus_valid && beat == $past(beat) + 1'b1));

    // R3: an accepted flush starts at word 0
    p_start_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid && flush_req) |=> (bus_valid && beat == '0));

    // R8: final accepted beat ends the burst
    p_end_on_last_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && bus_last) |=> !bus_valid);

    // R8: a flush during a burst does not disturb it
    p_busy_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_last && flush_req) |=> ($stable(bus_addr) && $stable(cur_q)));

endmodule

// File: rtl/sq_burst_writer.sv
module sq_burst_writer
    import sqbw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_wr_valid,
    output logic        cpu_wr_ready,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    input  logic        ctl_wr_en,
    input  logic        ctl_sel,
    input  logic [31:0] ctl_wdata,
    input  logic        flush_req,
    input  logic [31:0] flush_addr,
    input  logic        flush_xlat,
    output logic        busy,
    output logic        bus_valid,
    input  logic        bus_ready,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_data,
    output logic        bus_last
);

    burst_cmd_t        cmd;
    logic [QSEL_W-1:0] cur_q;
    logic [WIDX_W-1:0] beat;
    logic [IDX_W-1:0]  cpu_idx;
    logic              hit_drain;
    logic              wr_go;

    assign cpu_idx      = word_index(cpu_addr);
    assign hit_drain    = bus_valid && (cpu_idx[IDX_W-1 -: QSEL_W] == cur_q);
    assign cpu_wr_ready = !hit_drain;
    assign wr_go        = cpu_wr_valid && cpu_wr_ready;
    assign busy         = bus_valid;

    sqbw_target u_target (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr_en  (ctl_wr_en),
        .ctl_sel    (ctl_sel),
        .ctl_wdata  (ctl_wdata),
        .flush_addr (flush_addr),
        .flush_xlat (flush_xlat),
        .cmd        (cmd)
    );

    sqbw_burst_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .flush_req (flush_req),
        .cmd       (cmd),
        .bus_ready (bus_ready),
        .bus_valid (bus_valid),
        .bus_last  (bus_last),
        .bus_addr  (bus_addr),
        .cur_q     (cur_q),
        .beat      (beat)
    );

    sqbw_storage u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_go),
        .wr_idx       (cpu_idx),
        .wr_data      (cpu_wdata),
        .rd_idx       (cpu_idx),
        .rd_data      (cpu_rdata),
        .burst_active (bus_valid),
        .burst_idx    ({cur_q, beat}),
        .burst_data   (bus_data)
    );

    // R4/R6: burst target is line aligned and inside the physical window
    p_target_window_r4: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_addr[LINE_OFF_W-1:0] == '0 && bus_addr[ADDR_W-1:PHYS_W] == '0));

endmodule

// File: tb/sq_burst_writer_tb.sv
module sq_burst_writer_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] fa;
        logic        xl;
        logic [31:0] exp_addr;
        logic [3:0]  stall;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{32'hE000_1234, 1'b0, 32'h1C00_1220, 4'd0},
        '{32'hE3FF_FFC0, 1'b0, 32'h17FF_FFC0, 4'd2},
        '{32'hFFFF_FFFF, 1'b1, 32'h1FFF_FFE0, 4'd1},
        '{32'h0ABC_DE1F, 1'b1, 32'h0ABC_DE00, 4'd3},
        '{32'h0000_0020, 1'b0, 32'h1C00_0020, 4'd0}
    };

    logic clk = 1'b0;
    logic rst;
    logic cpu_wr_valid, cpu_wr_ready;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic ctl_wr_en, ctl_sel;
    logic [31:0] ctl_wdata;
    logic flush_req, flush_xlat;
    logic [31:0] flush_addr;
    logic busy, bus_valid, bus_ready, bus_last;
    logic [31:0] bus_addr, bus_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sq_burst_writer dut_i (
        .clk(clk), .rst(rst),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ctl_wr_en(ctl_wr_en), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .flush_req(flush_req), .flush_addr(flush_addr), .flush_xlat(flush_xlat),
        .busy(busy), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_last(bus_last)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr_valid = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr_valid = 1'b0;
        model[a[5:2]] = d;
    endtask

    task automatic ctl_write(input logic s, input logic [31:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_sel = s; ctl_wdata = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic start_flush(input logic [31:0] fa, input logic xl, input logic [31:0] ea);
        @(negedge clk);
        flush_req = 1'b1; flush_addr = fa; flush_xlat = xl;
        @(negedge clk);
        flush_req = 1'b0;
        chk(busy && bus_valid, "R8 busy after accept", {31'd0, busy}, 32'd1);
        chk(bus_addr == ea, (xl ? "R6 target" : "R4 target"), bus_addr, ea);
    endtask

    task automatic drain(input logic q, input logic [31:0] ea, input int stall);
        for (int b = 0; b < 8; b++) begin
            for (int s = 0; s < stall; s++) begin
                bus_ready = 1'b0;
                @(negedge clk);
                chk(bus_valid && bus_addr == ea && bus_data == model[{q, 3'(b)}], "R7 stall hold", bus_data, model[{q, 3'(b)}]);
            end
            chk(bus_data == model[{q, 3'(b)}], "R3 beat data", bus_data, model[{q, 3'(b)}]);
            chk(bus_last == (b == 7), "R3 last flag", {31'd0, bus_last}, {31'd0, b == 7});
            bus_ready = 1'b1;
            @(negedge clk);
            bus_ready = 1'b0;
        end
        chk(!busy && !bus_valid, "R8 idle after last", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_wr_valid = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        ctl_wr_en = 1'b0; ctl_sel = 1'b0; ctl_wdata = '0;
        flush_req = 1'b0; flush_addr = '0; flush_xlat = 1'b0; bus_ready = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(!busy && !bus_valid, "R1 idle", {31'd0, busy}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            cpu_addr = 32'(i) << 2;
            #1;
            chk(cpu_rdata == 32'd0, "R1 word zero", cpu_rdata, 32'd0);
        end
        // R1: high fields zero -> untranslated target has zero bits 28:26
        start_flush(32'h0000_1460, 1'b0, 32'h0000_1460);
        drain(1'b1, 32'h0000_1460, 0);

        // R2: stray high address bits ignored; bit5 picks buffer
        cpu_store(32'hFFFF_FF84, 32'h1111_2222);
        cpu_addr = 32'h0000_0004; #1;
        chk(cpu_rdata == 32'h1111_2222, "R2 word select", cpu_rdata, 32'h1111_2222);
        cpu_addr = 32'h0000_0024; #1;
        chk(cpu_rdata == 32'd0, "R2 buffer select", cpu_rdata, 32'd0);

        // R5: only bits 4:2 kept
        ctl_write(1'b0, 32'hFFFF_FFF7);  // field = 101
        ctl_write(1'b1, 32'h0000_001C);  // field = 111

        for (int v = 0; v < NV; v++) begin
            for (int w = 0; w < 16; w++)
                cpu_store(32'(w) << 2, 32'hC0DE_0000 + 32'(v * 256 + w));
            start_flush(VECS[v].fa, VECS[v].xl, VECS[v].exp_addr);
            drain(VECS[v].fa[5], VECS[v].exp_addr, int'(VECS[v].stall));
        end

        // R9/R8: store hold-off and dropped flush
        start_flush(32'h0000_0040, 1'b1, 32'h0000_0040);
        cpu_wr_valid = 1'b1; cpu_addr = 32'h0000_000C; cpu_wdata = 32'hDEAD_0003;
        #1;
        chk(!cpu_wr_ready, "R9 stall same buffer", {31'd0, cpu_wr_ready}, 32'd0);
        @(negedge clk);
        chk(cpu_rdata == model[3], "R9 word unchanged", cpu_rdata, model[3]);
        cpu_addr = 32'h0000_0028; cpu_wdata = 32'hBEEF_0012;
        flush_req = 1'b1; flush_addr = 32'h0000_0FE0; flush_xlat = 1'b1;
        #1;
        chk(cpu_wr_ready, "R9 other buffer ready", {31'd0, cpu_wr_ready}, 32'd1);
        @(negedge clk);
        flush_req = 1'b0; cpu_wr_valid = 1'b0;
        model[10] = 32'hBEEF_0012;
        chk(cpu_rdata == 32'hBEEF_0012, "R9 other buffer stored", cpu_rdata, 32'hBEEF_0012);
        chk(bus_addr == 32'h0000_0040, "R8 busy flush dropped", bus_addr, 32'h0000_0040);
        drain(1'b0, 32'h0000_0040, 0);
        @(negedge clk);
        chk(!busy, "R8 no late burst", {31'd0, busy}, 32'd0);
        cpu_store(32'h0000_000C, 32'hDEAD_0003);
        cpu_addr = 32'h0000_000C; #1;
        chk(cpu_rdata == 32'hDEAD_0003, "R9 store after drain", cpu_rdata, 32'hDEAD_0003);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule